// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block is the command front end of a NOR-style flash device, limited to the sector erase path. It receives bus writes, each given as a one-cycle strobe with a word address and a data byte. It tracks the six-write unlock and sector-erase sequence. Once that sequence is accepted, the block opens a retriggering acceptance window. Inside the window the host may add more sectors; a foreign command inside the window cancels everything.

When the window lapses, a modelled embedded erase starts. Pending sectors are handled one at a time, lowest index first. Each sector spends a preprogram phase, which drives the sector to zeros, and then an erase phase. The bit for that sector in the pending bitmap clears when its erase phase ends. While erasing, the block acts only on a suspend command. A suspended erase continues from the point where it stopped once a resume command arrives.

Top module: `sector_erase_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `tmr_o`, `susp_o`, `prog_o` are 0 and `sect_o` is all zeros.
- R2: The six writes AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, then 30@SA are accepted. The unlock addresses are matched on the offset bits below the sector field. The sixth write sets `sect_o[SA[ADDR_W-1 -: SECT_BITS]]` and raises `busy_o` after its edge.
- R3: A write whose address or data does not match the next unlock step returns the sequencer to read mode. A later 30 then starts nothing.
- R4: The window stays open for WIN_CYC cycles after the last accepted 30 write. Each 30 write inside the window marks its sector, in any order, and restarts the window.
- R5: Inside the window, a write with data other than 30 or B0 clears `sect_o` and drops `busy_o` at its edge. No erase follows.
- R6: A B0 write inside the window changes nothing and does not restart the window.
- R7: `tmr_o` is 0 in read mode and inside the window. It is 1 from the edge at which the window expires until the erase finishes, and this includes time spent suspended.
- R8: Sectors are erased in ascending index order. Each sector takes PREP_CYC cycles with `prog_o`=1, then ERASE_CYC cycles, and its bit clears at the end. `busy_o` and `tmr_o` fall at the edge that clears the last bit.
- R9: During erase, every write other than B0 is ignored and does not change the finishing time.
- R10: B0 during erase sets `susp_o`, clears `busy_o` and freezes progress. Non-30 writes are ignored while suspended. A 30 resumes the erase with the remaining cycle count unchanged.
- R11: Asserting `rst_ni` aborts an erase at once and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Word address of the write |
| data_i | input | 8 | Command data of the write |
| busy_o | output | 1 | Window open or erase running |
| tmr_o | output | 1 | Window expired, erase begun |
| susp_o | output | 1 | Erase suspended |
| prog_o | output | 1 | Preprogram phase of the current sector active |
| sect_o | output | 2**SECT_BITS | Pending sector bitmap |

## Verification
The assertions assume that `wr_i` is a clean, one-cycle-per-write strobe with stable address and data in that cycle. They also assume WIN_CYC is at least 2, so that a window restart cannot expire in the cycle that follows it. The bench drives every input at the falling clock edge and issues each write as a single strobe cycle. It keeps the gap between writes inside the window shorter than WIN_CYC, except where a test deliberately lets the window lapse.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_SETUP, ST_UL3, ST_UL4, ST_WIN, ST_ERASE, ST_SUSP
  } st_e;

  localparam logic [10:0] ADR_A    = 11'h555;
  localparam logic [10:0] ADR_B    = 11'h2AA;
  localparam logic [7:0]  D_UNLK1  = 8'hAA;
  localparam logic [7:0]  D_UNLK2  = 8'h55;
  localparam logic [7:0]  D_SETUP  = 8'h80;
  localparam logic [7:0]  D_SERASE = 8'h30;
  localparam logic [7:0]  D_SUSP   = 8'hB0;
endpackage

// File: rtl/sec_win_timer.sv
module sec_win_timer #(
  parameter int WIN_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(WIN_CYC - 1));

  // restart must never expire in the following cycle (WIN_CYC >= 2)
  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !expired_o);
endmodule

// File: rtl/sec_erase_eng.sv
module sec_erase_eng #(
  parameter int SECT_BITS = 3,
  parameter int PREP_CYC  = 64,
  parameter int ERASE_CYC = 1024
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        mark_i,
  input  logic [SECT_BITS-1:0]        mark_idx_i,
  input  logic                        clr_i,
  input  logic                        run_i,
  output logic [(1<<SECT_BITS)-1:0]   pend_o,
  output logic                        prog_o,
  output logic                        fin_o
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int MAXC  = (PREP_CYC > ERASE_CYC) ? PREP_CYC : ERASE_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  logic [NSECT-1:0] pend_q, pend_d, cur_oh, mark_oh;
  logic [CW-1:0]    cnt_q;
  logic             ers_q;
  logic             step, last_pre, last_ers;

  // lowest pending sector goes first
  assign cur_oh   = pend_q & (~pend_q + {{(NSECT-1){1'b0}}, 1'b1});
  assign step     = run_i && (pend_q != '0);
  assign last_pre = cnt_q == CW'(PREP_CYC - 1);
  assign last_ers = cnt_q == CW'(ERASE_CYC - 1);

  for (genvar g = 0; g < NSECT; g++) begin : g_mark
    assign mark_oh[g] = mark_i && (mark_idx_i == SECT_BITS'(g));
  end

  always_comb begin
    pend_d = pend_q | mark_oh;
    if (step && ers_q && last_ers) pend_d = pend_d & ~cur_oh;
    if (clr_i) pend_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ers_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (clr_i) begin
        ers_q <= 1'b0;
        cnt_q <= '0;
      end else if (step) begin
        if (!ers_q) begin
          if (last_pre) begin
            ers_q <= 1'b1;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end else if (last_ers) begin
          ers_q <= 1'b0;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
  assign prog_o = step && !ers_q;
  assign fin_o  = step && ers_q && last_ers && ((pend_q & ~cur_oh) == '0);

  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> (($past(pend_q) & ~pend_q) == '0));
  assert_one_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones($past(pend_q) & ~pend_q) <= 1));
endmodule

// File: rtl/sec_cmd_fsm.sv
module sec_cmd_fsm
  import sec_erase_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           data_i,
  input  logic                 expired_i,
  input  logic                 fin_i,
  output logic                 win_start_o,
  output logic                 win_run_o,
  output logic                 mark_o,
  output logic [SECT_BITS-1:0] mark_idx_o,
  output logic                 clr_o,
  output logic                 run_o,
  output logic                 busy_o,
  output logic                 tmr_o,
  output logic                 susp_o
);
  localparam int OFS_W = ADDR_W - SECT_BITS;

  st_e  st_q, st_d;
  logic is_a, is_b, d_ers, d_sus;

  assign is_a  = addr_i[OFS_W-1:0] == OFS_W'(ADR_A);
  assign is_b  = addr_i[OFS_W-1:0] == OFS_W'(ADR_B);
  assign d_ers = data_i == D_SERASE;
  assign d_sus = data_i == D_SUSP;
  assign mark_idx_o = addr_i[ADDR_W-1 -: SECT_BITS];

  always_comb begin
    st_d   = st_q;
    mark_o = 1'b0;
    clr_o  = 1'b0;
    unique case (st_q)
      ST_READ:  if (wr_i && is_a && data_i == D_UNLK1) st_d = ST_UL1;
      ST_UL1:   if (wr_i) st_d = (is_b && data_i == D_UNLK2) ? ST_UL2   : ST_READ;
      ST_UL2:   if (wr_i) st_d = (is_a && data_i == D_SETUP) ? ST_SETUP : ST_READ;
      ST_SETUP: if (wr_i) st_d = (is_a && data_i == D_UNLK1) ? ST_UL3   : ST_READ;
      ST_UL3:   if (wr_i) st_d = (is_b && data_i == D_UNLK2) ? ST_UL4   : ST_READ;
      ST_UL4:
        if (wr_i) begin
          if (d_ers) begin
            st_d   = ST_WIN;
            mark_o = 1'b1;
          end else st_d = ST_READ;
        end
      ST_WIN:
        if (wr_i) begin
          if (d_ers) mark_o = 1'b1;
          else if (!d_sus) begin
            st_d  = ST_READ;
            clr_o = 1'b1;
          end
        end else if (expired_i) st_d = ST_ERASE;
      ST_ERASE:
        if (fin_i) st_d = ST_READ;
        else if (wr_i && d_sus) st_d = ST_SUSP;
      ST_SUSP:  if (wr_i && d_ers) st_d = ST_ERASE;
      default:  st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_READ;
    else         st_q <= st_d;
  end

  assign win_start_o = mark_o;
  assign win_run_o   = st_q == ST_WIN;
  assign run_o       = st_q == ST_ERASE;
  assign busy_o      = (st_q == ST_WIN) || (st_q == ST_ERASE);
  assign tmr_o       = (st_q == ST_ERASE) || (st_q == ST_SUSP);
  assign susp_o      = st_q == ST_SUSP;

  assert_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WIN && wr_i && !d_ers && !d_sus) |=> (st_q == ST_READ));
  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERASE && wr_i && !d_sus && !fin_i) |=> (st_q == ST_ERASE));
  assert_hold_susp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP && !(wr_i && d_ers)) |=> (st_q == ST_SUSP));
  assert_tmr_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_o) |-> ($past(st_q) == ST_WIN && $past(expired_i)));
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq #(
  parameter int ADDR_W    = 16,
  parameter int SECT_BITS = 3,
  parameter int WIN_CYC   = 2500,
  parameter int PREP_CYC  = 64,
  parameter int ERASE_CYC = 1024
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                data_i,
  output logic                      busy_o,
  output logic                      tmr_o,
  output logic                      susp_o,
  output logic                      prog_o,
  output logic [(1<<SECT_BITS)-1:0] sect_o
);
  logic                 win_start, win_run, expired;
  logic                 mark, clr, run, fin;
  logic [SECT_BITS-1:0] mark_idx;

  sec_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_fsm (
    .clk_i, .rst_ni, .wr_i, .addr_i, .data_i,
    .expired_i   (expired),
    .fin_i       (fin),
    .win_start_o (win_start),
    .win_run_o   (win_run),
    .mark_o      (mark),
    .mark_idx_o  (mark_idx),
    .clr_o       (clr),
    .run_o       (run),
    .busy_o, .tmr_o, .susp_o
  );

  sec_win_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .start_i   (win_start),
    .run_i     (win_run),
    .expired_o (expired)
  );

  sec_erase_eng #(.SECT_BITS(SECT_BITS), .PREP_CYC(PREP_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk_i, .rst_ni,
    .mark_i     (mark),
    .mark_idx_i (mark_idx),
    .clr_i      (clr),
    .run_i      (run),
    .pend_o     (sect_o),
    .prog_o,
    .fin_o      (fin)
  );

  assert_done_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tmr_o) && !$past(susp_o)) |-> (sect_o == '0));
endmodule

// File: tb/sector_erase_seq_bench.sv
module sector_erase_seq_bench;
  localparam int PERIOD = 10;
  localparam int AW = 13, SB = 2, NS = 1 << SB;
  localparam int W = 8, P = 3, E = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic          busy_o, tmr_o, susp_o, prog_o;
  logic [NS-1:0] sect_o;
  int n_vec = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  sector_erase_seq #(.ADDR_W(AW), .SECT_BITS(SB), .WIN_CYC(W), .PREP_CYC(P), .ERASE_CYC(E))
    u_sector_erase_seq (.clk_i(clk), .rst_ni, .wr_i, .addr_i, .data_i,
                        .busy_o, .tmr_o, .susp_o, .prog_o, .sect_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  function automatic logic [AW-1:0] sa(input int s);
    return AW'(s) << (AW - SB);
  endfunction

  task automatic seq(input int s);
    wr(13'h555, 8'hAA); wr(13'h2AA, 8'h55); wr(13'h555, 8'h80);
    wr(13'h555, 8'hAA); wr(13'h2AA, 8'h55); wr(sa(s), 8'h30);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lo;
    logic [NS-1:0] rem;
    idle(2);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 sect in reset", sect_o, 0);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 busy", busy_o, 0); chk("R1 tmr", tmr_o, 0);
    chk("R1 susp", susp_o, 0); chk("R1 prog", prog_o, 0);
    chk("R1 sect", sect_o, 0);

    // R2 R4 R7 R8: sweep every non-empty sector set, extras in descending order
    for (int m = 1; m < (1 << NS); m++) begin
      lo = 0;
      while (!m[lo]) lo++;
      seq(lo);
      chk("R2 busy after seq", busy_o, 1);
      for (int s = NS - 1; s > lo; s--) if (m[s]) wr(sa(s), 8'h30);
      chk("R4 sect collected", sect_o, m);
      idle(W - 1);
      chk("R4 window still open", tmr_o, 0);
      chk("R7 busy in window", busy_o, 1);
      idle(1);
      chk("R7 tmr after expiry", tmr_o, 1);
      chk("R8 prog at start", prog_o, 1);
      rem = NS'(m);
      while (rem != 0) begin
        idle(P);
        chk("R8 prog ends", prog_o, 0);
        chk("R8 sect during erase", sect_o, rem);
        idle(E);
        rem = rem & (rem - 1'b1);
        chk("R8 ascending clear", sect_o, rem);
        if (rem == 0) begin
          chk("R8 busy done", busy_o, 0);
          chk("R7 tmr done", tmr_o, 0);
        end else chk("R8 next prog", prog_o, 1);
      end
      idle(2);
    end

    // R5 abort
    seq(1);
    wr(13'h0, 8'hF0);
    chk("R5 busy", busy_o, 0); chk("R5 sect", sect_o, 0);
    idle(W + 2);
    chk("R5 no erase", tmr_o, 0); chk("R5 still idle", busy_o, 0);

    // R6 B0 in window ignored, no restart
    seq(2);
    idle(3);
    wr(13'h0, 8'hB0);
    idle(W - 5);
    chk("R6 tmr", tmr_o, 0); chk("R6 busy", busy_o, 1); chk("R6 sect", sect_o, 4'b0100);
    idle(1);
    chk("R6 expired on time", tmr_o, 1);
    idle(P + E);
    chk("R6 done", busy_o, 0); chk("R6 sect done", sect_o, 0);

    // R3 unlock mismatches
    wr(13'h555, 8'hAA); wr(13'h2AA, 8'h55); wr(13'h555, 8'h80);
    wr(13'h555, 8'hAA); wr(13'h2AA, 8'h56); wr(sa(0), 8'h30);
    chk("R3 bad data", busy_o, 0); chk("R3 bad data sect", sect_o, 0);
    wr(13'h554, 8'hAA); wr(13'h2AA, 8'h55); wr(13'h555, 8'h80);
    wr(13'h555, 8'hAA); wr(13'h2AA, 8'h55); wr(sa(0), 8'h30);
    chk("R3 bad addr", busy_o, 0); chk("R3 bad addr sect", sect_o, 0);
    seq(3);
    chk("R2 after mismatch", sect_o, 4'b1000);
    idle(W + P + E);
    chk("R2 completes", busy_o, 0);

    // R9 writes ignored during erase
    seq(0);
    idle(W);
    wr(13'h555, 8'hAA); wr(13'h0, 8'hF0); wr(13'h555, 8'h80);
    chk("R9 busy", busy_o, 1); chk("R9 tmr", tmr_o, 1);
    chk("R9 susp", susp_o, 0); chk("R9 sect", sect_o, 4'b0001);
    idle(P + E - 4);
    chk("R9 not early", busy_o, 1);
    idle(1);
    chk("R9 finish time", busy_o, 0); chk("R9 sect cleared", sect_o, 0);

    // R10 suspend / resume
    seq(1);
    idle(W);
    wr(13'h0, 8'hB0);
    chk("R10 susp", susp_o, 1); chk("R10 busy", busy_o, 0);
    chk("R10 tmr", tmr_o, 1); chk("R10 prog", prog_o, 0);
    idle(20);
    chk("R10 frozen sect", sect_o, 4'b0010); chk("R10 still susp", susp_o, 1);
    wr(13'h555, 8'hF0);
    chk("R10 ignore in susp", susp_o, 1);
    wr(13'h0, 8'h30);
    chk("R10 resumed busy", busy_o, 1); chk("R10 resumed susp", susp_o, 0);
    idle(P + E - 2);
    chk("R10 remaining", busy_o, 1); chk("R10 in erase phase", prog_o, 0);
    idle(1);
    chk("R10 finish", busy_o, 0); chk("R10 sect", sect_o, 0);

    // R11 reset mid-erase
    seq(2);
    idle(W + 2);
    rst_ni = 1'b0;
    #1;
    chk("R11 busy", busy_o, 0); chk("R11 sect", sect_o, 0); chk("R11 tmr", tmr_o, 0);
    idle(1);
    rst_ni = 1'b1;
    idle(1);
    seq(0);
    idle(W + P + E);
    chk("R11 usable after", busy_o, 0); chk("R11 sect after", sect_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule